// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Port

This block is the programming port of a fractional-N frequency synthesizer. A host drives three wires: a serial clock, a data line and an active-low chip select. Bits are sampled on each rising edge of the serial clock while chip select is low. The rising edge of chip select closes the frame. A complete frame is captured, carried into the reference-clock domain through a toggle handshake, decoded there, and written into a small register file. That file holds the integer divider, the fractional dividend, a modulation word, the charge-pump gain and a control field.

A normal frame carries an address and a payload. When the control field enables short frames, a shorter address-less frame loads the modulation word directly, which saves host bus time during modulation. Frames of any other length are thrown away. A separate one-bit modulation pin is brought into the reference domain through its own synchronizer.

Top module: `tw_prog_port`

## Requirements
- R1: After reset every register field reads zero, except the power-down bit, which reads 1. The short-frame enable and `busy` both read 0.
- R2: A 16-bit frame is shifted MSB first on rising `sclk` edges while `cs_n` is low. Bits [15:12] are the address and bits [11:0] are the payload. The address map is: 0 = `div_int`; 1 = `frac[23:12]`; 2 = `frac[11:0]`; 3 = `mod_word`; 4 = `cp_gain` (payload bits [2:0]); 5 = control, with payload bit 0 driving `pwr_dn` and bit 1 driving `short_en`.
- R3: A 16-bit frame addressed to 6 through 15 changes no output field.
- R4: A frame whose bit count at the rising edge of `cs_n` is neither 16 nor a valid short length changes no output field. This covers 15, 17 and 13 bits.
- R5: With `short_en` = 1, a 12-bit frame writes its 12 bits into `mod_word` and leaves every other field unchanged.
- R6: With `short_en` = 0, a 12-bit frame is discarded.
- R7: With `short_en` = 1, 16-bit frames still write by address.
- R8: With the default two-stage synchronizers, a frame that closes just after a falling `ref_clk` edge shows on the outputs after the third rising `ref_clk` edge that follows. Register outputs change at no other time.
- R9: `busy` rises when a frame is captured. It stays high until the reference domain has taken the frame and two further `sclk` rising edges have carried that acknowledgement back. A frame that closes while `busy` is high is dropped.
- R10: `mod_pin_sync` equals `mod_pin` as it was two `ref_clk` rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock, the register domain |
| rst | input | 1 | Active-high reset, asynchronous assert |
| sclk | input | 1 | Serial clock, data sampled on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| cs_n | input | 1 | Active-low frame select; its rising edge ends a frame |
| mod_pin | input | 1 | Direct modulation data pin |
| busy | output | 1 | Captured frame not yet acknowledged back to the serial side |
| div_int | output | PAY_W | Integer divider value |
| frac | output | 2*PAY_W | Fractional dividend |
| mod_word | output | PAY_W | Modulation word |
| cp_gain | output | CP_W | Charge-pump gain code |
| pwr_dn | output | 1 | Synthesizer power-down |
| short_en | output | 1 | Short-frame mode enable |
| mod_pin_sync | output | 1 | `mod_pin` resynchronized to `ref_clk` |

## Verification
The bench writes each address with distinct payloads. Because one payload sets bit 1, a write to an unused address would expose any decode that wraps onto the control field.

Frames of 15, 17 and 13 bits are used because their last 16 shifted bits still look like valid frames. They separate a length check from a decode that trusts the shift register alone. The same 12-bit pattern is sent once with short mode off and once with it on, which proves that the mode bit, and not the length alone, routes the frame.

A second frame packed inside the handshake window of the first is used to check the overwrite gate and the sticky `busy` flag. A cycle-accurate model checks the exact reference-clock edge at which every write lands.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // register addresses carried in the top bits of a full frame
  localparam int A_DIV     = 0;
  localparam int A_FRAC_HI = 1;
  localparam int A_FRAC_LO = 2;
  localparam int A_MOD     = 3;
  localparam int A_CP      = 4;
  localparam int A_CTRL    = 5;
  // bit positions inside the control payload
  localparam int CTRL_PD_BIT    = 0;
  localparam int CTRL_SHORT_BIT = 1;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_rx_shift.sv
module tw_rx_shift #(
  parameter int FRAME_BITS  = 16,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  sdata,
  input  logic                  cs_n,
  input  logic                  ack_tgl,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic [CNT_W-1:0]      frame_len,
  output logic                  req_tgl,
  output logic                  busy
);
  logic [FRAME_BITS-1:0]  shreg;
  logic [CNT_W-1:0]       bitcnt;
  logic [SYNC_STAGES-1:0] ack_s;
  logic                   clr;

  assign clr = rst | cs_n;

  // shift register, sampled on rising serial clock inside a frame
  always_ff @(posedge sclk or posedge rst) begin
    if (rst)        shreg <= '0;
    else if (!cs_n) shreg <= {shreg[FRAME_BITS-2:0], sdata};
  end

  // saturating bit counter, held clear while the frame is idle
  always_ff @(posedge sclk or posedge clr) begin
    if (clr)               bitcnt <= '0;
    else if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
  end

  // acknowledgement carried back on the serial clock
  always_ff @(posedge sclk or posedge rst) begin
    if (rst) ack_s <= '0;
    else     ack_s <= {ack_s[SYNC_STAGES-2:0], ack_tgl};
  end

  assign busy = req_tgl ^ ack_s[SYNC_STAGES-1];

  // frame end: hold word and length, raise a request unless one is pending
  always_ff @(posedge cs_n or posedge rst) begin
    if (rst) begin
      frame_word <= '0;
      frame_len  <= '0;
      req_tgl    <= 1'b0;
    end else if (!busy) begin
      frame_word <= shreg;
      frame_len  <= bitcnt;
      req_tgl    <= ~req_tgl;
    end
  end
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PAY_W  = 12,
  parameter int CP_W   = 3,
  parameter int CNT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_sync,
  input  logic [ADDR_W+PAY_W-1:0] frame_word,
  input  logic [CNT_W-1:0]        frame_len,
  output logic                    ack_tgl,
  output logic                    frame_evt,
  output logic [PAY_W-1:0]        div_int,
  output logic [2*PAY_W-1:0]      frac,
  output logic [PAY_W-1:0]        mod_word,
  output logic [CP_W-1:0]         cp_gain,
  output logic                    pwr_dn,
  output logic                    short_en
);
  localparam int FRAME_BITS = ADDR_W + PAY_W;

  logic              req_d;
  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;
  logic              full_ok;
  logic              short_ok;

  assign frame_evt = req_sync ^ req_d;
  assign addr      = frame_word[FRAME_BITS-1 -: ADDR_W];
  assign pay       = frame_word[PAY_W-1:0];
  assign full_ok   = (frame_len == CNT_W'(FRAME_BITS));
  assign short_ok  = short_en && (frame_len == CNT_W'(PAY_W));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      req_d    <= 1'b0;
      ack_tgl  <= 1'b0;
      div_int  <= '0;
      frac     <= '0;
      mod_word <= '0;
      cp_gain  <= '0;
      pwr_dn   <= 1'b1;
      short_en <= 1'b0;
    end else begin
      req_d <= req_sync;
      if (frame_evt) begin
        ack_tgl <= req_sync;
        if (full_ok) begin
          case (addr)
            ADDR_W'(A_DIV):     div_int             <= pay;
            ADDR_W'(A_FRAC_HI): frac[2*PAY_W-1:PAY_W] <= pay;
            ADDR_W'(A_FRAC_LO): frac[PAY_W-1:0]     <= pay;
            ADDR_W'(A_MOD):     mod_word            <= pay;
            ADDR_W'(A_CP):      cp_gain             <= pay[CP_W-1:0];
            ADDR_W'(A_CTRL): begin
              pwr_dn   <= pay[CTRL_PD_BIT];
              short_en <= pay[CTRL_SHORT_BIT];
            end
            default: ;
          endcase
        end else if (short_ok) begin
          mod_word <= pay;
        end
      end
    end
  end
endmodule

// File: rtl/tw_prog_port.sv
module tw_prog_port #(
  parameter int ADDR_W      = 4,
  parameter int PAY_W       = 12,
  parameter int CP_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 ref_clk,
  input  logic                 rst,
  input  logic                 sclk,
  input  logic                 sdata,
  input  logic                 cs_n,
  input  logic                 mod_pin,
  output logic                 busy,
  output logic [PAY_W-1:0]     div_int,
  output logic [2*PAY_W-1:0]   frac,
  output logic [PAY_W-1:0]     mod_word,
  output logic [CP_W-1:0]      cp_gain,
  output logic                 pwr_dn,
  output logic                 short_en,
  output logic                 mod_pin_sync
);
  localparam int FRAME_BITS = ADDR_W + PAY_W;
  localparam int CNT_W      = $clog2(FRAME_BITS) + 2;

  logic [FRAME_BITS-1:0] frame_word;
  logic [CNT_W-1:0]      frame_len;
  logic                  req_tgl;
  logic                  req_sync;
  logic                  ack_tgl;
  logic                  frame_evt;

  tw_rx_shift #(
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .rst       (rst),
    .sclk      (sclk),
    .sdata     (sdata),
    .cs_n      (cs_n),
    .ack_tgl   (ack_tgl),
    .frame_word(frame_word),
    .frame_len (frame_len),
    .req_tgl   (req_tgl),
    .busy      (busy)
  );

  tw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(ref_clk),
    .rst(rst),
    .d  (req_tgl),
    .q  (req_sync)
  );

  tw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mod_sync (
    .clk(ref_clk),
    .rst(rst),
    .d  (mod_pin),
    .q  (mod_pin_sync)
  );

  tw_regfile #(
    .ADDR_W(ADDR_W),
    .PAY_W (PAY_W),
    .CP_W  (CP_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk       (ref_clk),
    .rst       (rst),
    .req_sync  (req_sync),
    .frame_word(frame_word),
    .frame_len (frame_len),
    .ack_tgl   (ack_tgl),
    .frame_evt (frame_evt),
    .div_int   (div_int),
    .frac      (frac),
    .mod_word  (mod_word),
    .cp_gain   (cp_gain),
    .pwr_dn    (pwr_dn),
    .short_en  (short_en)
  );
endmodule

// File: rtl/tw_prog_port_chk.sv
module tw_prog_port_chk #(
  parameter int PAY_W      = 12,
  parameter int CP_W       = 3,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_evt,
  input logic [CNT_W-1:0]   frame_len,
  input logic [PAY_W-1:0]   div_int,
  input logic [2*PAY_W-1:0] frac,
  input logic [PAY_W-1:0]   mod_word,
  input logic [CP_W-1:0]    cp_gain,
  input logic               pwr_dn,
  input logic               short_en,
  input logic               mod_pin,
  input logic               mod_pin_sync
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != '1) since_rst <= since_rst + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwr_dn && !short_en && div_int == '0 && mod_word == '0));

  assert_write_only_on_event_R8: assert property (@(posedge clk) disable iff (rst)
    (!$stable(div_int) || !$stable(frac) || !$stable(mod_word) || !$stable(cp_gain)
     || !$stable(pwr_dn) || !$stable(short_en)) |-> $past(frame_evt));

  assert_bad_length_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && frame_len != CNT_W'(FRAME_BITS) && frame_len != CNT_W'(PAY_W)) |=>
    ($stable(div_int) && $stable(frac) && $stable(mod_word) && $stable(cp_gain)
     && $stable(pwr_dn) && $stable(short_en)));

  assert_short_off_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && !short_en && frame_len == CNT_W'(PAY_W)) |=>
    ($stable(div_int) && $stable(frac) && $stable(mod_word) && $stable(cp_gain)
     && $stable(pwr_dn) && $stable(short_en)));

  assert_short_only_mod_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_evt && short_en && frame_len == CNT_W'(PAY_W)) |=>
    ($stable(div_int) && $stable(frac) && $stable(cp_gain) && $stable(short_en)));

  assert_mod_pin_delay_R10: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (mod_pin_sync == $past(mod_pin, 2)));
endmodule

bind tw_prog_port tw_prog_port_chk #(
  .PAY_W     (PAY_W),
  .CP_W      (CP_W),
  .FRAME_BITS(FRAME_BITS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (ref_clk),
  .rst         (rst),
  .frame_evt   (frame_evt),
  .frame_len   (frame_len),
  .div_int     (div_int),
  .frac        (frac),
  .mod_word    (mod_word),
  .cp_gain     (cp_gain),
  .pwr_dn      (pwr_dn),
  .short_en    (short_en),
  .mod_pin     (mod_pin),
  .mod_pin_sync(mod_pin_sync)
);

// File: tb/test_tw_prog_port.sv
`timescale 1ns/10ps
module test_tw_prog_port;
  localparam int CLK_PERIOD = 10;

  logic ref_clk = 1'b0;
  logic rst     = 1'b0;
  logic sclk    = 1'b0;
  logic sdata   = 1'b0;
  logic cs_n    = 1'b1;
  logic mod_pin = 1'b0;
  logic        busy;
  logic [11:0] div_int;
  logic [23:0] frac;
  logic [11:0] mod_word;
  logic [2:0]  cp_gain;
  logic        pwr_dn;
  logic        short_en;
  logic        mod_pin_sync;

  tw_prog_port i_tw_prog_port (
    .ref_clk(ref_clk), .rst(rst), .sclk(sclk), .sdata(sdata), .cs_n(cs_n),
    .mod_pin(mod_pin), .busy(busy), .div_int(div_int), .frac(frac),
    .mod_word(mod_word), .cp_gain(cp_gain), .pwr_dn(pwr_dn),
    .short_en(short_en), .mod_pin_sync(mod_pin_sync)
  );

  always #(CLK_PERIOD/2.0) ref_clk = ~ref_clk;

  // reference model state
  logic [11:0] m_div = '0, m_mod = '0;
  logic [23:0] m_frac = '0;
  logic [2:0]  m_cp = '0;
  logic        m_pd = 1'b1, m_short = 1'b0;
  logic [15:0] pend_word = '0;
  int  pend_len  = 0;
  int  countdown = 0;
  bit  inflight  = 0;
  bit  acked     = 0;
  int  ack_edges = 0;
  bit  cmp_on    = 0;
  bit  done      = 0;
  int  vectors   = 0;
  int  fails     = 0;

  function automatic bit m_busy();
    return inflight && !(acked && ack_edges >= 2);
  endfunction

  function automatic void apply_pending();
    if (pend_len == 16) begin
      case (pend_word[15:12])
        4'd0: m_div = pend_word[11:0];
        4'd1: m_frac[23:12] = pend_word[11:0];
        4'd2: m_frac[11:0] = pend_word[11:0];
        4'd3: m_mod = pend_word[11:0];
        4'd4: m_cp = pend_word[2:0];
        4'd5: begin m_pd = pend_word[0]; m_short = pend_word[1]; end
        default: ;
      endcase
    end else if (pend_len == 12 && m_short) begin
      m_mod = pend_word[11:0];
    end
    acked = 1;
    ack_edges = 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the whole register image against the model
  always @(negedge ref_clk) begin
    if (cmp_on && !done) begin
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) apply_pending();
      end
      chk("R8 register image",
          64'({div_int, frac, mod_word, cp_gain, pwr_dn, short_en}),
          64'({m_div, m_frac, m_mod, m_cp, m_pd, m_short}));
    end
  end

  task automatic capture_end(input logic [31:0] bits, input int nbits);
    if (!m_busy()) begin
      pend_word = bits[15:0];
      pend_len  = nbits;
      countdown = 3;
      inflight  = 1;
      acked     = 0;
    end
  endtask

  task automatic send(input logic [31:0] bits, input int nbits);
    @(negedge ref_clk); #1;
    cs_n = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = bits[i];
      #2 sclk = 1'b1;
      if (acked) ack_edges++;
      #2 sclk = 1'b0;
    end
    @(negedge ref_clk); #1;
    cs_n = 1'b1;
    capture_end(bits, nbits);
  endtask

  task automatic send_fast(input logic [31:0] bits, input int nbits);
    #1 cs_n = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = bits[i];
      #0.25 sclk = 1'b1;
      if (acked) ack_edges++;
      #0.25 sclk = 1'b0;
    end
    #0.5 cs_n = 1'b1;
    capture_end(bits, nbits);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge ref_clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] p);
    send({16'h0, a, p}, 16);
    idle(5);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #1 rst = 1'b1;
    repeat (4) @(negedge ref_clk);
    rst = 1'b0;
    cmp_on = 1;
    #2;
    // R1 reset state
    chk("R1 pwr_dn", 64'(pwr_dn), 64'd1);
    chk("R1 short_en", 64'(short_en), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 fields", 64'({div_int, frac, mod_word, cp_gain}), 64'd0);

    // R8 exact landing edge, R2 divider write
    send({16'h0, 4'd0, 12'hABC}, 16);
    @(negedge ref_clk); #2 chk("R8 before second edge", 64'(div_int), 64'h0);
    @(negedge ref_clk); #2 chk("R8 before third edge", 64'(div_int), 64'h0);
    @(negedge ref_clk); #2 chk("R8 R2 after third edge", 64'(div_int), 64'hABC);
    idle(3);

    wr(4'd1, 12'h123);
    wr(4'd2, 12'h456);
    chk("R2 frac", 64'(frac), 64'h123456);
    wr(4'd4, 12'hFF5);
    chk("R2 cp_gain", 64'(cp_gain), 64'd5);
    wr(4'd5, 12'h000);
    chk("R2 pwr_dn cleared", 64'(pwr_dn), 64'd0);

    // R3 unused address
    wr(4'd9, 12'hFFF);
    chk("R3 unused address", 64'({div_int, frac, cp_gain, pwr_dn, short_en}),
        64'({12'hABC, 24'h123456, 3'd5, 1'b0, 1'b0}));

    // R4 wrong lengths
    send(32'h0555, 15); idle(5);
    chk("R4 15-bit frame", 64'(div_int), 64'hABC);
    send(32'h00777, 17); idle(5);
    chk("R4 17-bit frame", 64'(div_int), 64'hABC);

    // R6 short frame while disabled
    send(32'h9A5, 12); idle(5);
    chk("R6 short frame ignored", 64'(mod_word), 64'h0);

    // R5 short mode
    wr(4'd5, 12'h002);
    chk("R5 short_en set", 64'(short_en), 64'd1);
    send(32'h9A5, 12); idle(5);
    chk("R5 short frame to mod", 64'(mod_word), 64'h9A5);
    chk("R5 divider untouched", 64'(div_int), 64'hABC);

    // R7 full frames in short mode
    wr(4'd0, 12'h321);
    chk("R7 divider write", 64'(div_int), 64'h321);
    wr(4'd3, 12'h0F0);
    chk("R7 mod write", 64'(mod_word), 64'h0F0);
    send(32'h1ABC, 13); idle(5);
    chk("R4 13-bit frame in short mode", 64'(mod_word), 64'h0F0);

    // R9 overwrite gate
    send({16'h0, 4'd0, 12'h111}, 16);
    send_fast({16'h0, 4'd0, 12'h222}, 16);
    idle(6);
    chk("R9 busy held without sclk", 64'(busy), 64'd1);
    chk("R9 second frame dropped", 64'(div_int), 64'h111);
    wr(4'd0, 12'h333);
    chk("R9 later frame accepted", 64'(div_int), 64'h333);

    // R10 modulation pin
    @(negedge ref_clk); #1 mod_pin = 1'b1;
    @(negedge ref_clk); #2 chk("R10 one edge", 64'(mod_pin_sync), 64'd0);
    @(negedge ref_clk); #2 chk("R10 two edges", 64'(mod_pin_sync), 64'd1);
    @(negedge ref_clk); #1 mod_pin = 1'b0;
    @(negedge ref_clk); #2 chk("R10 fall one edge", 64'(mod_pin_sync), 64'd1);
    @(negedge ref_clk); #2 chk("R10 fall two edges", 64'(mod_pin_sync), 64'd0);

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule